// File: doc/BRIEF.md
# Burst-of-Two SRAM Command Sequencer

This block is the command-side control of a synchronous double-data-rate SRAM with a shared data bus and a fixed burst length of two. On every rising clock edge it samples an active-low start strobe and a read/write select. A low start strobe begins a new access and captures the address. The select then makes it a read or a write. A high start strobe sends the sequencer to idle and leaves the captured address untouched.

Each accepted command yields two beats. Both beat addresses are presented at once for the cycle that follows the command, so the datapath can place them on the two clock edges of that one cycle. They share the upper address bits. The lowest bit follows a two-entry linear order that wraps: a start bit of 0 gives 0 then 1, and a start bit of 1 gives 1 then 0. Because the whole burst fits in one cycle, a new command can be taken on every edge. Read and write commands can follow each other directly, with no idle cycle between them. A read-data-valid flag follows each read cycle after a fixed, parameterised number of cycles.

Top module: `bseq_burst2`

## Requirements
- R1: While rst_ni is low, state_o is 0 (idle), rd_en_o, wr_en_o and data_valid_o are 0, beat0_addr_o is 0 and beat1_addr_o is 1.
- R2: When start_ni is high at a rising edge, state_o is 0 (idle) and both strobes are 0 in the following cycle, whatever the previous state.
- R3: When start_ni is low and is_read_i is high at a rising edge, the next cycle shows state_o = 1 (read), rd_en_o = 1 and wr_en_o = 0.
- R4: When start_ni is low and is_read_i is low at a rising edge, the next cycle shows state_o = 2 (write), wr_en_o = 1 and rd_en_o = 0.
- R5: After an accepted command, beat0_addr_o equals the address sampled with that command.
- R6: After an accepted command, beat1_addr_o has the same upper bits as the sampled address, with bit 0 inverted (linear order 0,1 or wrapped order 1,0).
- R7: Commands on consecutive edges are each honoured with no idle cycle between them, including read-to-write and write-to-read changes.
- R8: data_valid_o is 1 exactly RD_LAT cycles (default 1) after a cycle with state_o = 1, and 0 otherwise.
- R9: While start_ni is high, beat0_addr_o and beat1_addr_o keep the values from the last accepted command, even when addr_i changes.
- R10: rd_en_o and wr_en_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock; commands are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_ni | input | 1 | Start strobe, active low: begins a new burst |
| is_read_i | input | 1 | 1 = read, 0 = write; used when start_ni is low |
| addr_i | input | ADDR_W | Burst start address |
| state_o | output | 2 | 0 idle, 1 read, 2 write |
| beat0_addr_o | output | ADDR_W | Address of the first beat |
| beat1_addr_o | output | ADDR_W | Address of the second beat |
| rd_en_o | output | 1 | Read strobe for the current burst cycle |
| wr_en_o | output | 1 | Write strobe for the current burst cycle |
| data_valid_o | output | 1 | Read data valid, RD_LAT cycles after a read cycle |

## Verification
Directed sequences come first. Single reads and writes with start bit 0 and with start bit 1 separate the linear beat order from the wrapped order. Unbroken read/write alternation would expose any idle gap inserted between commands. Idle stretches with a changing address show whether the address is wrongly reloaded without a start. A long random mix of start, select and address values, checked against a queued reference model, tests every state transition and the read-valid delay after each of them. A reset in the middle of traffic confirms that the state, the strobes and the held addresses return to their reset values.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int unsigned BURST_LEN = 2;
  localparam int unsigned BEAT_IDX_W = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  function automatic seq_state_e next_state(input logic start_n, input logic is_read);
    if (start_n) return ST_IDLE;
    return is_read ? ST_READ : ST_WRITE;
  endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_ni,
  input  logic       is_read_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       rd_en_o,
  output logic       wr_en_o
);

  seq_state_e state_q, state_d;

  always_comb state_d = next_state(start_ni, is_read_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // capture strobe for the address register, same edge as state
  assign load_o  = ~start_ni;
  assign state_o = state_q;
  assign rd_en_o = (state_q == ST_READ);
  assign wr_en_o = (state_q == ST_WRITE);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ni |=> (!rd_en_o && !wr_en_o && state_o == ST_IDLE));

  p_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_ni && is_read_i) |=> (rd_en_o && !wr_en_o));

  p_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_ni && !is_read_i) |=> (wr_en_o && !rd_en_o));

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, wr_en_o}));

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned BUS_W = ADDR_W * BURST_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BUS_W-1:0]  beats_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  // linear burst counter on the low bits, wrapping; upper bits fixed
  for (genvar k = 0; k < BURST_LEN; k++) begin : g_beat
    logic [BEAT_IDX_W-1:0] low;
    assign low = addr_q[BEAT_IDX_W-1:0] + BEAT_IDX_W'(k);
    assign beats_o[k*ADDR_W +: ADDR_W] = {addr_q[ADDR_W-1:BEAT_IDX_W], low};
  end

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beats_o[ADDR_W-1:0] == $past(addr_i)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(beats_o));

endmodule

// File: rtl/bseq_valid_pipe.sv
module bseq_valid_pipe #(
  parameter int unsigned LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);

  if (LAT == 0) begin : g_comb
    assign out_o = in_i;
  end else begin : g_pipe
    logic [LAT-1:0] sh_q;
    for (genvar i = 0; i < LAT; i++) begin : g_stage
      logic src;
      if (i == 0) begin : g_first
        assign src = in_i;
      end else begin : g_next
        assign src = sh_q[i-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[i] <= 1'b0;
        else         sh_q[i] <= src;
      end
    end
    assign out_o = sh_q[LAT-1];

    if (LAT == 1) begin : g_chk
      p_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_i |=> out_o);
      p_nolat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_i |=> !out_o);
    end
  end

endmodule

// File: rtl/bseq_burst2.sv
module bseq_burst2
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned RD_LAT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ni,
  input  logic              is_read_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        state_o,
  output logic [ADDR_W-1:0] beat0_addr_o,
  output logic [ADDR_W-1:0] beat1_addr_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              data_valid_o
);

  localparam int unsigned BUS_W = ADDR_W * BURST_LEN;

  seq_state_e       state;
  logic             load;
  logic [BUS_W-1:0] beats;

  bseq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_ni  (start_ni),
    .is_read_i (is_read_i),
    .state_o   (state),
    .load_o    (load),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o)
  );

  bseq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .beats_o (beats)
  );

  bseq_valid_pipe #(.LAT(RD_LAT)) u_vpipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (rd_en_o),
    .out_o  (data_valid_o)
  );

  assign state_o      = state;
  assign beat0_addr_o = beats[0 +: ADDR_W];
  assign beat1_addr_o = beats[ADDR_W +: ADDR_W];

  p_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ni |=> (beat1_addr_o == {$past(addr_i[ADDR_W-1:1]), ~$past(addr_i[0])}));

  p_b2b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_ni && (state_o != 2'd0)) |=> (state_o != 2'd0));

endmodule

// File: tb/bseq_burst2_test.sv
module bseq_burst2_test;

  localparam int AW = 10;

  typedef struct {
    logic [1:0]    st;
    logic [AW-1:0] b0;
    logic [AW-1:0] b1;
    logic          rd;
    logic          wr;
    logic          dv;
    logic          loaded;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_n = 1'b1;
  logic          is_rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    state;
  logic [AW-1:0] b0, b1;
  logic          rd_en, wr_en, dv;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  // model state
  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_prev = 2'd0;

  always #2 clk = ~clk;

  bseq_burst2 #(.ADDR_W(AW), .RD_LAT(1)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_ni     (start_n),
    .is_read_i    (is_rd),
    .addr_i       (addr),
    .state_o      (state),
    .beat0_addr_o (b0),
    .beat1_addr_o (b1),
    .rd_en_o      (rd_en),
    .wr_en_o      (wr_en),
    .data_valid_o (dv)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic sn, input logic rdsel, input logic [AW-1:0] a,
                     input string tag);
    exp_t e;
    @(negedge clk);
    start_n = sn;
    is_rd   = rdsel;
    addr    = a;
    if (!sn) begin
      e.st = rdsel ? 2'd1 : 2'd2;
      m_addr = a;
    end else begin
      e.st = 2'd0;
    end
    e.b0 = m_addr;
    e.b1 = {m_addr[AW-1:1], ~m_addr[0]};
    e.rd = (e.st == 2'd1);
    e.wr = (e.st == 2'd2);
    e.dv = (m_prev == 2'd1);
    e.loaded = !sn;
    e.tag = tag;
    m_prev = e.st;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(state == e.st, e.tag, "state", state, e.st);
      check(rd_en == e.rd, e.tag, "rd_en", rd_en, e.rd);
      check(wr_en == e.wr, e.tag, "wr_en", wr_en, e.wr);
      check(b0 == e.b0, e.loaded ? "R5" : "R9", "beat0", b0, e.b0);
      check(b1 == e.b1, e.loaded ? "R6" : "R9", "beat1", b1, e.b1);
      check(dv == e.dv, "R8", "data_valid", dv, e.dv);
      check(!(rd_en && wr_en), "R10", "strobe_excl", {rd_en, wr_en}, 0);
    end
  end

  task automatic check_reset_outputs();
    check(state == 2'd0, "R1", "state", state, 0);
    check(!rd_en && !wr_en, "R1", "strobes", {rd_en, wr_en}, 0);
    check(dv == 1'b0, "R1", "data_valid", dv, 0);
    check(b0 == '0, "R1", "beat0", b0, 0);
    check(b1 == AW'(1), "R1", "beat1", b1, 1);
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    start_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check_reset_outputs();
    @(negedge clk);
    #1;
    check_reset_outputs();
    rst_n = 1'b1;
    m_addr = '0;
    m_prev = 2'd0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset_outputs();
    @(negedge clk);
    rst_n = 1'b1;

    cmd(1'b1, 1'b0, 10'h155, "R2");   // idle, addr ignored
    cmd(1'b0, 1'b1, 10'h0A4, "R3");   // read, low bit 0
    cmd(1'b1, 1'b1, 10'h3FF, "R2");
    cmd(1'b0, 1'b1, 10'h0A5, "R3");   // read, low bit 1 wraps
    cmd(1'b1, 1'b0, 10'h000, "R2");
    cmd(1'b0, 1'b0, 10'h2C0, "R4");   // write, low bit 0
    cmd(1'b0, 1'b0, 10'h2C1, "R7");   // write back-to-back, wrap
    cmd(1'b0, 1'b1, 10'h111, "R7");   // write -> read
    cmd(1'b0, 1'b0, 10'h222, "R7");   // read -> write
    cmd(1'b0, 1'b1, 10'h333, "R7");
    cmd(1'b0, 1'b1, 10'h3FF, "R7");   // read -> read
    for (int i = 0; i < 4; i++) cmd(1'b1, i[0], AW'(i * 97 + 5), "R2");
    for (int i = 0; i < 8; i++) cmd(1'b0, i[0], AW'(i * 131 + 3), "R7");
    cmd(1'b1, 1'b0, 10'h001, "R2");

    do_reset();

    for (int i = 0; i < 400; i++) begin
      logic sn, rs;
      logic [AW-1:0] a;
      string tg;
      sn = ($urandom_range(0, 2) == 0);
      rs = $urandom_range(0, 1) == 1;
      a  = AW'($urandom());
      if (sn)                tg = "R2";
      else if (m_prev != 0)  tg = "R7";
      else if (rs)           tg = "R3";
      else                   tg = "R4";
      cmd(sn, rs, a, tg);
      if (i == 200) do_reset();
    end
    cmd(1'b1, 1'b0, '0, "R2");
    cmd(1'b1, 1'b0, '0, "R2");
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule